// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block owns a ring of receive buffer descriptors for a network receive path. Each descriptor is 64 bits: a 16-bit status word, a 16-bit length and a 32-bit buffer pointer. The descriptors sit in local storage that the host fills and inspects through a simple read/write port. Software hands a descriptor to the engine by setting its empty bit. When the MAC reports a completed frame, the engine fills the current descriptor with the frame length and error flags, clears the empty bit and moves to the next descriptor.

A per-descriptor wrap bit closes the ring by sending the engine back to a programmable base index. If a frame arrives while the current descriptor still belongs to software, the engine raises a busy event and halts until a halt-clear pulse arrives. A graceful stop request lets the frame in progress complete, then parks the engine and raises a stop event. Both events are sticky and are cleared by writing a one.

The buffer pointer of the current descriptor is presented continuously to the downstream data writer. Moving payload data is not part of this block.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the index is 0, both events and the halted and stopped flags are low, and every descriptor reads as all zeros.
- R2: A host write stores `host_wdata` into descriptor `host_addr` at the next clock edge. `host_rdata` always shows descriptor `host_addr` as {status[63:48], length[47:32], pointer[31:0]}.
- R3: `buf_ptr` always equals the pointer field of the descriptor at `cur_idx`.
- R4: When a frame completes and the current descriptor has its empty bit (status bit 15) set, the engine writes back as follows. Length becomes `frm_len` plus 4, to count the frame check sequence. Status bit 15 is cleared and bit 11 (last) is set. Bits [ERR_W-1:0] take `frm_err`. All other status bits and the pointer keep their values. A nonzero error field marks a bad frame.
- R5: After an accepted frame the index moves to `ring_base` if status bit 13 (wrap) of that descriptor was set. Otherwise it moves to the next index, going from NUM_DESC-1 to 0.
- R6: A frame that completes while the engine runs and the current descriptor is not empty sets `evt_busy` and `rx_halted`. It leaves the descriptor and the index unchanged.
- R7: A frame that completes while the engine is halted or stopped is dropped, and no descriptor or index changes.
- R8: A `halt_clr` pulse clears `rx_halted` so that reception resumes. It does not clear `evt_busy`.
- R9: After a `stop_req` pulse, `rx_stopped` and `evt_stop` rise at the first clock edge after the request edge where `frm_busy` is low. Frames that complete before that are still processed.
- R10: A `start` pulse loads `cur_idx` with `ring_base` and clears the halted, stopped and pending-stop state. It leaves the events alone, and a frame completing in the same cycle is dropped.
- R11: `evt_clr` bit 0 clears `evt_busy` and bit 1 clears `evt_stop`. A zero bit has no effect, and a new event in the same cycle wins over the clear.
- R12: When an engine write-back and a host write target the same descriptor in one cycle, the engine write-back is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse: index to ring base, clear halt/stop |
| ring_base | input | IDX_W | Index of the first descriptor of the ring |
| stop_req | input | 1 | Graceful stop request pulse |
| halt_clr | input | 1 | Clear-halt pulse (resume after busy) |
| evt_clr | input | 2 | Write-one-to-clear: bit 0 busy, bit 1 stop |
| host_we | input | 1 | Host descriptor write enable |
| host_addr | input | IDX_W | Host descriptor index |
| host_wdata | input | 64 | Descriptor to write |
| host_rdata | output | 64 | Descriptor at host_addr |
| frm_done | input | 1 | Frame-complete pulse from the MAC |
| frm_busy | input | 1 | MAC is in the middle of a frame |
| frm_len | input | 16 | Frame byte count without check sequence |
| frm_err | input | ERR_W | Frame error flags |
| buf_ptr | output | 32 | Buffer pointer of the current descriptor |
| cur_idx | output | IDX_W | Current descriptor index |
| evt_busy | output | 1 | Sticky busy (no empty descriptor) event |
| evt_stop | output | 1 | Sticky stop-complete event |
| rx_halted | output | 1 | Reception halted after busy |
| rx_stopped | output | 1 | Reception stopped after graceful stop |

## Verification
Every result of this block registers on the first clock edge after the cycle that carries its stimulus. This covers write-back, index move, halt, events and host writes, while `buf_ptr` and `host_rdata` follow combinationally from that registered state. The bench drives inputs 2 ns after a rising edge and advances its reference model as of the next edge. It then compares every output 2 ns after that edge, one edge after the stimulus. The one two-step case is graceful stop: the request is first registered, and completion appears one edge later when `frm_busy` is low. The bench checks that the flag is still low after the first edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int STAT_W = 16;
   localparam int LEN_W  = 16;
   localparam int PTR_W  = 32;
   localparam int DESC_W = STAT_W + LEN_W + PTR_W;

   // status word bit positions decoded by software
   localparam int EMPTY_POS = 15;
   localparam int WRAP_POS  = 13;
   localparam int LAST_POS  = 11;

   typedef struct packed {
      logic [STAT_W-1:0] status;
      logic [LEN_W-1:0]  len;
      logic [PTR_W-1:0]  ptr;
   } rxr_desc_t;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram
   import rxr_pkg::*;
#(
   parameter  int NUM_DESC = 8,
   localparam int IDX_W    = $clog2(NUM_DESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_addr,
   input  rxr_desc_t        host_wdata,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_addr,
   input  rxr_desc_t        eng_wdata,
   output rxr_desc_t        host_rd,
   input  logic [IDX_W-1:0] cur_addr,
   output rxr_desc_t        cur_rd
);

   rxr_desc_t mem [NUM_DESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DESC; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_DESC; i++) begin
            if (eng_we && (eng_addr == IDX_W'(i)))
               mem[i] <= eng_wdata;
            else if (host_we && (host_addr == IDX_W'(i)))
               mem[i] <= host_wdata;
         end
      end
   end

   always_comb begin
      host_rd = '0;
      cur_rd  = '0;
      for (int i = 0; i < NUM_DESC; i++) begin
         if (host_addr == IDX_W'(i)) host_rd = mem[i];
         if (cur_addr  == IDX_W'(i)) cur_rd  = mem[i];
      end
   end

endmodule

// File: rtl/rxr_index.sv
module rxr_index #(
   parameter  int NUM_DESC = 8,
   localparam int IDX_W    = $clog2(NUM_DESC),
   localparam bit POW2     = (NUM_DESC == (1 << IDX_W))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] ring_base,
   input  logic             advance,
   input  logic             wrap,
   output logic [IDX_W-1:0] cur_idx
);

   logic [IDX_W-1:0] next_seq;
   logic [IDX_W-1:0] base_ok;

   // a base beyond the ring falls back to entry 0
   assign base_ok = (32'(ring_base) < NUM_DESC) ? ring_base : '0;

   generate
      if (POW2) begin : g_pow2
         assign next_seq = cur_idx + 1'b1;
      end else begin : g_cmp
         assign next_seq = (32'(cur_idx) == NUM_DESC - 1) ? '0 : cur_idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur_idx <= '0;
      else if (start)   cur_idx <= base_ok;
      else if (advance) cur_idx <= wrap ? base_ok : next_seq;
   end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       stop_req,
   input  logic       halt_clr,
   input  logic [1:0] evt_clr,
   input  logic       frm_done,
   input  logic       frm_busy,
   input  logic       cur_empty,
   output logic       accept,
   output logic       rx_halted,
   output logic       rx_stopped,
   output logic       evt_busy,
   output logic       evt_stop
);

   logic stop_pend;
   logic running;
   logic busy_hit;
   logic stop_done;

   assign running   = !rx_halted && !rx_stopped;
   assign accept    = frm_done && running &&  cur_empty && !start;
   assign busy_hit  = frm_done && running && !cur_empty && !start;
   assign stop_done = stop_pend && !frm_busy && !rx_stopped && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_halted  <= 1'b0;
         rx_stopped <= 1'b0;
         stop_pend  <= 1'b0;
      end else if (start) begin
         rx_halted  <= 1'b0;
         rx_stopped <= 1'b0;
         stop_pend  <= 1'b0;
      end else begin
         if (busy_hit)      rx_halted <= 1'b1;
         else if (halt_clr) rx_halted <= 1'b0;
         if (stop_done) begin
            rx_stopped <= 1'b1;
            stop_pend  <= 1'b0;
         end else if (stop_req && !rx_stopped) begin
            stop_pend  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_busy <= 1'b0;
         evt_stop <= 1'b0;
      end else begin
         if (busy_hit)        evt_busy <= 1'b1;
         else if (evt_clr[0]) evt_busy <= 1'b0;
         if (stop_done)       evt_stop <= 1'b1;
         else if (evt_clr[1]) evt_stop <= 1'b0;
      end
   end

endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
   import rxr_pkg::*;
#(
   parameter  int NUM_DESC  = 8,
   parameter  int ERR_W     = 6,
   parameter  int FCS_BYTES = 4,
   localparam int IDX_W     = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  ring_base,
   input  logic              stop_req,
   input  logic              halt_clr,
   input  logic [1:0]        evt_clr,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_addr,
   input  logic [63:0]       host_wdata,
   output logic [63:0]       host_rdata,
   input  logic              frm_done,
   input  logic              frm_busy,
   input  logic [15:0]       frm_len,
   input  logic [ERR_W-1:0]  frm_err,
   output logic [31:0]       buf_ptr,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              evt_busy,
   output logic              evt_stop,
   output logic              rx_halted,
   output logic              rx_stopped
);

   initial begin
      assert (NUM_DESC >= 2) else $error("NUM_DESC must be at least 2");
      assert (ERR_W >= 1 && ERR_W <= LAST_POS)
         else $error("ERR_W must fit below the last-flag bit");
      assert (FCS_BYTES >= 0 && FCS_BYTES < 256) else $error("FCS_BYTES out of range");
   end

   rxr_desc_t cur_desc;
   rxr_desc_t host_desc;
   rxr_desc_t wb_desc;
   logic      cur_empty;
   logic      cur_wrap;
   logic      accept;

   assign cur_empty  = cur_desc.status[EMPTY_POS];
   assign cur_wrap   = cur_desc.status[WRAP_POS];
   assign buf_ptr    = cur_desc.ptr;
   assign host_rdata = host_desc;

   always_comb begin
      wb_desc                   = cur_desc;
      wb_desc.len               = frm_len + LEN_W'(FCS_BYTES);
      wb_desc.status[EMPTY_POS] = 1'b0;
      wb_desc.status[LAST_POS]  = 1'b1;
      wb_desc.status[ERR_W-1:0] = frm_err;
   end

   rxr_desc_ram #(.NUM_DESC(NUM_DESC)) u_ram (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (rxr_desc_t'(host_wdata)),
      .eng_we     (accept),
      .eng_addr   (cur_idx),
      .eng_wdata  (wb_desc),
      .host_rd    (host_desc),
      .cur_addr   (cur_idx),
      .cur_rd     (cur_desc)
   );

   rxr_index #(.NUM_DESC(NUM_DESC)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ring_base (ring_base),
      .advance   (accept),
      .wrap      (cur_wrap),
      .cur_idx   (cur_idx)
   );

   rxr_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .stop_req   (stop_req),
      .halt_clr   (halt_clr),
      .evt_clr    (evt_clr),
      .frm_done   (frm_done),
      .frm_busy   (frm_busy),
      .cur_empty  (cur_empty),
      .accept     (accept),
      .rx_halted  (rx_halted),
      .rx_stopped (rx_stopped),
      .evt_busy   (evt_busy),
      .evt_stop   (evt_stop)
   );

endmodule

// File: rtl/rxr_ring_engine_chk.sv
module rxr_ring_engine_chk #(
   parameter int NUM_DESC = 8,
   parameter int IDX_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [IDX_W-1:0] ring_base,
   input logic             frm_done,
   input logic [1:0]       evt_clr,
   input logic             cur_empty,
   input logic             cur_wrap,
   input logic [IDX_W-1:0] cur_idx,
   input logic             evt_busy,
   input logic             evt_stop,
   input logic             rx_halted,
   input logic             rx_stopped
);

   // R6
   busy_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !rx_halted && !rx_stopped && !cur_empty && !start
      |=> evt_busy && rx_halted && $stable(cur_idx));

   // R7
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && (rx_halted || rx_stopped) && !start |=> $stable(cur_idx));

   // R11
   busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_busy && !evt_clr[0] |=> evt_busy);

   // R10
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && (32'(ring_base) < NUM_DESC)
      |=> (cur_idx == $past(ring_base)) && !rx_halted && !rx_stopped);

   // R9
   stop_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_stopped) |-> evt_stop);

   // R5
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !rx_halted && !rx_stopped && cur_empty && !cur_wrap && !start
      |=> 32'(cur_idx) == (32'($past(cur_idx)) + 1) % NUM_DESC);

endmodule

bind rxr_ring_engine rxr_ring_engine_chk #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .ring_base  (ring_base),
   .frm_done   (frm_done),
   .evt_clr    (evt_clr),
   .cur_empty  (cur_empty),
   .cur_wrap   (cur_wrap),
   .cur_idx    (cur_idx),
   .evt_busy   (evt_busy),
   .evt_stop   (evt_stop),
   .rx_halted  (rx_halted),
   .rx_stopped (rx_stopped)
);

// File: tb/rxr_ring_engine_test.sv
`timescale 1ns/1ps
module rxr_ring_engine_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 0, stop_req = 0, halt_clr = 0, host_we = 0;
   logic        frm_done = 0, frm_busy = 0;
   logic [2:0]  ring_base = 0, host_addr = 0, cur_idx;
   logic [1:0]  evt_clr = 0;
   logic [63:0] host_wdata = 0, host_rdata;
   logic [15:0] frm_len = 0;
   logic [5:0]  frm_err = 0;
   logic [31:0] buf_ptr;
   logic        evt_busy, evt_stop, rx_halted, rx_stopped;

   int n_chk = 0, n_err = 0;
   logic [63:0] m_desc [N];
   logic [2:0]  m_idx;
   bit m_halt, m_stop, m_pend, m_eb, m_es;

   always #5 clk = ~clk;

   rxr_ring_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
      .stop_req(stop_req), .halt_clr(halt_clr), .evt_clr(evt_clr),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .frm_done(frm_done), .frm_busy(frm_busy),
      .frm_len(frm_len), .frm_err(frm_err), .buf_ptr(buf_ptr),
      .cur_idx(cur_idx), .evt_busy(evt_busy), .evt_stop(evt_stop),
      .rx_halted(rx_halted), .rx_stopped(rx_stopped));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] wb(input logic [63:0] d, input logic [15:0] len,
                                      input logic [5:0] err);
      logic [63:0] r = d;
      r[63] = 1'b0;
      r[59] = 1'b1;
      r[53:48] = err;
      r[47:32] = len + 16'd4;
      return r;
   endfunction

   // reference model advanced as of the coming clock edge
   task automatic model_edge();
      logic [63:0] cur = m_desc[m_idx];
      bit run  = !m_halt && !m_stop;
      bit acc  = frm_done && run && cur[63] && !start;
      bit bhit = frm_done && run && !cur[63] && !start;
      bit sdn  = m_pend && !frm_busy && !m_stop && !start;
      if (host_we && !(acc && host_addr == m_idx)) m_desc[host_addr] = host_wdata;
      if (acc) begin
         m_desc[m_idx] = wb(cur, frm_len, frm_err);
         m_idx = cur[61] ? ring_base : m_idx + 3'd1;
      end
      if (start) begin
         m_idx = ring_base; m_halt = 0; m_stop = 0; m_pend = 0;
      end else begin
         if (bhit) m_halt = 1; else if (halt_clr) m_halt = 0;
         if (sdn) begin m_stop = 1; m_pend = 0; end
         else if (stop_req && !m_stop) m_pend = 1;
      end
      if (bhit) m_eb = 1; else if (evt_clr[0]) m_eb = 0;
      if (sdn)  m_es = 1; else if (evt_clr[1]) m_es = 0;
   endtask

   task automatic compare_all();
      chk("R5 index", 64'(cur_idx), 64'(m_idx));
      chk("R3 buf_ptr", 64'(buf_ptr), 64'(m_desc[m_idx][31:0]));
      chk("R6 busy event", 64'(evt_busy), 64'(m_eb));
      chk("R8 halted", 64'(rx_halted), 64'(m_halt));
      chk("R9 stopped", 64'(rx_stopped), 64'(m_stop));
      chk("R9 stop event", 64'(evt_stop), 64'(m_es));
      chk("R2 host read", host_rdata, m_desc[host_addr]);
   endtask

   task automatic cyc();
      model_edge();
      @(posedge clk);
      #2;
      start = 0; stop_req = 0; halt_clr = 0; evt_clr = 0; host_we = 0; frm_done = 0;
      compare_all();
   endtask

   task automatic frame(input logic [15:0] len, input logic [5:0] err);
      frm_done = 1; frm_len = len; frm_err = err;
      cyc();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_desc[i] = '0;
      m_idx = 0; m_halt = 0; m_stop = 0; m_pend = 0; m_eb = 0; m_es = 0;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      chk("R1 index", 64'(cur_idx), 0);
      chk("R1 events", 64'({evt_busy, evt_stop, rx_halted, rx_stopped}), 0);
      chk("R1 descriptor", host_rdata, 0);
      chk("R1 buf_ptr", 64'(buf_ptr), 0);

      // fill ring: empty + software bit 6, wrap on entry 2
      for (int i = 0; i < N; i++) begin
         host_we = 1; host_addr = 3'(i);
         host_wdata = {16'h8040 | ((i == 2) ? 16'h2000 : 16'h0), 16'h0,
                       32'h1000_0000 + 32'(i) * 32'h100};
         cyc();
      end
      host_addr = 3'd5; #1;
      chk("R2 readback", host_rdata, 64'h8040_0000_1000_0500);
      chk("R3 pointer of entry 0", 64'(buf_ptr), 64'h1000_0000);

      host_addr = 0;
      frame(16'd60, 6'h0);
      chk("R4 length with FCS", 64'(host_rdata[47:32]), 64'd64);
      chk("R4 status", 64'(host_rdata[63:48]), 64'h0840);
      chk("R5 next index", 64'(cur_idx), 1);
      host_addr = 1;
      frame(16'd100, 6'h15);
      chk("R4 error bits", 64'(host_rdata[63:48]), 64'h0855);
      frame(16'd10, 6'h0);
      chk("R5 wrap to base", 64'(cur_idx), 0);

      host_addr = 0;
      frame(16'd33, 6'h3);
      chk("R6 busy set", 64'({evt_busy, rx_halted}), 64'b11);
      chk("R6 descriptor untouched", host_rdata, 64'h0840_0040_1000_0000);
      frame(16'd44, 6'h0);
      chk("R7 drop while halted", host_rdata, 64'h0840_0040_1000_0000);
      chk("R7 index held", 64'(cur_idx), 0);

      evt_clr = 2'b10; cyc();
      chk("R11 other bit no effect", 64'(evt_busy), 1);
      halt_clr = 1; cyc();
      chk("R8 resume keeps event", 64'({evt_busy, rx_halted}), 64'b10);
      evt_clr = 2'b01; cyc();
      chk("R11 busy cleared", 64'(evt_busy), 0);

      ring_base = 3; start = 1; cyc();
      chk("R10 start index", 64'(cur_idx), 3);

      frm_busy = 1; stop_req = 1; cyc();
      chk("R9 waits for frame", 64'(rx_stopped), 0);
      host_addr = 3;
      frame(16'd70, 6'h0);
      chk("R9 frame finished", 64'(host_rdata[47:32]), 64'd74);
      frm_busy = 0; cyc();
      chk("R9 stopped", 64'({rx_stopped, evt_stop}), 64'b11);
      host_addr = 4;
      frame(16'd80, 6'h0);
      chk("R7 drop while stopped", 64'({cur_idx, host_rdata[63]}), 64'({3'd4, 1'b1}));

      ring_base = 7; start = 1; cyc();
      chk("R10 start keeps event", 64'({cur_idx, rx_stopped, evt_stop}), 64'({3'd7, 2'b01}));
      evt_clr = 2'b10; cyc();
      frame(16'd20, 6'h0);
      chk("R5 end of ring to 0", 64'(cur_idx), 0);

      host_addr = 0; host_we = 1; host_wdata = 64'h8000_0000_2222_0000; cyc();
      host_we = 1; host_wdata = 64'h8000_0000_3333_0000;
      frame(16'd8, 6'h0);
      chk("R12 engine wins", host_rdata, 64'h0800_000C_2222_0000);

      ring_base = 0;
      for (int k = 0; k < 3000; k++) begin
         frm_done = ($urandom_range(99) < 30);
         frm_len  = 16'($urandom_range(1518));
         frm_err  = ($urandom_range(99) < 20) ? 6'($urandom) : 6'h0;
         frm_busy = ($urandom_range(99) < 40);
         stop_req = ($urandom_range(99) < 2);
         start    = ($urandom_range(99) < 2);
         halt_clr = ($urandom_range(99) < 10);
         evt_clr  = ($urandom_range(99) < 10) ? 2'($urandom) : 2'b00;
         host_we  = ($urandom_range(99) < 35);
         host_addr = 3'($urandom);
         host_wdata = {($urandom_range(99) < 75), 1'b0,
                       ($urandom_range(99) < 15), 13'($urandom), 16'($urandom), 32'($urandom)};
         if ($urandom_range(99) < 3) ring_base = 3'($urandom);
         cyc();
      end

      summary();
      $finish;
   end
endmodule